// File: doc/BRIEF.md
# Stage-2 Intermediate Address Translation Walker

This block turns an intermediate physical address (IPA) into a physical address by walking stage-2 translation tables held in memory. A single `start` pulse delivers the IPA and the access type (read or write). The walker first applies two checks on the input address. It then fetches one 8-byte descriptor per level over a simple request/response read port, until it reaches a block or page leaf. At that leaf it checks the access flag, the stage-2 access permissions and the output address range.

The walker supports two granules, 4 KB and 64 KB. A small encoding selects the start level. The top-level table may be made of several contiguous tables placed back to back and indexed as one larger table. The result is reported with a one-cycle `done` pulse. On success the result holds the output block base, its offset mask, the leaf level and the permissions. On failure it holds a fault code and which stage the fault is attributed to. The translation configuration must stay stable while a walk is in progress.

Top module: `s2_ipa_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `busy`, `done` and `rd_req` are low.
- R2: When `cfg_s1_bypass` is 1 and `ipa` >= 2^`cfg_oas`, the walk ends with `fault`=4 (address size) and `fault_s2`=0, without any read. This check wins over every other fault.
- R3: When `ipa` >= 2^(64-`cfg_s2tsz`), or when `cfg_sl0`=3 (reserved), the walk ends with `fault`=1 (translation) and `fault_s2`=1, without any read.
- R4: The start level is 2-`cfg_sl0` with the 4 KB granule (`cfg_gran64k`=0) and 3-`cfg_sl0` with the 64 KB granule.
- R5: At the start level the table index takes stride+4 IPA bits, so up to 16 concatenated root tables are reached. The first read address is `cfg_vttb` + idx*2^stride*8 + offset*8. Here idx is the IPA bits just above the root index field.
- R6: Level l covers the IPA bits starting at shift = g+(3-l)*stride (g=12, stride=9 for 4 KB; g=16, stride=13 for 64 KB). Each read is at base + ((ipa>>shift) mod 2^stride)*8. A table descriptor (bit0=1, bit1=1, level<3) gives the next base as bits [47:g]. The walk then moves one level down, without any access-flag or permission check.
- R7: A leaf is a page (bit0=1, bit1=1) at level 3, or a block (bit0=1, bit1=0) at levels 1-2 for 4 KB or level 2 for 64 KB. A leaf yields `pa` = descriptor bits [47:shift] with the low bits cleared, `pa_mask` = 2^shift-1, `leaf_level`, and `perm` = descriptor bits [7:6] (bit 6 read, bit 7 write).
- R8: A descriptor with bit0=0, a block at a level where blocks are not allowed, or bit1=0 at level 3 ends the walk with `fault`=1 (translation).
- R9: A leaf with access flag bit 10 = 0 while `cfg_affd`=0 gives `fault`=2 (access). This takes priority over the permission check.
- R10: A leaf whose permission bit for the requested access type is 0 gives `fault`=3 (permission).
- R11: A leaf output address >= 2^`cfg_eff_ps` gives `fault`=4 (address size) with `fault_s2`=1.
- R12: A read answered with `rd_err` ends the walk with `fault`=5 (external abort) and `fault_s2`=1.
- R13: Every fault is reported with `done`, `perm`=0, and `fault_s2`=1, except the R2 fault.
- R14: `rd_req` and `rd_addr` hold steady until `rd_ack`. A `start` pulse that arrives during a walk is ignored, and each walk ends with exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (taken only when idle) |
| ipa | input | 64 | Address to translate |
| is_write | input | 1 | 1 = write access, 0 = read access |
| cfg_s1_bypass | input | 1 | Stage 1 bypassed: enable the input address-size check |
| cfg_oas | input | 6 | Input address size limit, log2 |
| cfg_s2tsz | input | 6 | Stage-2 size offset; input range is 2^(64-value) |
| cfg_gran64k | input | 1 | Granule: 0 = 4 KB, 1 = 64 KB |
| cfg_sl0 | input | 2 | Start level encoding |
| cfg_vttb | input | 48 | Root table base address |
| cfg_affd | input | 1 | Disable access-flag faults |
| cfg_eff_ps | input | 6 | Effective output address size, log2 |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 48 | Descriptor byte address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 64 | Descriptor read back |
| rd_err | input | 1 | Read response carries an error |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| fault | output | 3 | 0 none, 1 translation, 2 access, 3 permission, 4 address size, 5 external abort |
| fault_s2 | output | 1 | Fault attributed to stage 2 |
| pa | output | 48 | Output block or page base |
| pa_mask | output | 48 | Offset mask of the leaf |
| leaf_level | output | 2 | Level of the leaf |
| perm | output | 2 | Granted permissions {write, read} |

## Verification
Walks are driven through three-level page chains, early block leaves at levels 1 and 2, starts at levels 0 and 2, and a 64 KB chain. Together these separate the per-level shift and stride from the start-level decode. Two IPAs that differ only in the bit above the root field show whether the concatenated root index is honoured. Leaves that combine a clear access flag, missing permissions and an oversized output address pin down the order in which the leaf checks are applied. Oversized inputs with and without stage-1 bypass separate the stage-1 size fault from the stage-2 range fault, and neither may issue a read. A slow memory with a `start` pulse injected mid-walk exercises the handshake.

// File: rtl/s2_ipa_walker.sv
module s2_ipa_walker #(
  parameter int PA_W  = 48,
  parameter int IA_W  = 64,
  parameter int CAT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IA_W-1:0] ipa,
  input  logic            is_write,
  input  logic            cfg_s1_bypass,
  input  logic [5:0]      cfg_oas,
  input  logic [5:0]      cfg_s2tsz,
  input  logic            cfg_gran64k,
  input  logic [1:0]      cfg_sl0,
  input  logic [PA_W-1:0] cfg_vttb,
  input  logic            cfg_affd,
  input  logic [5:0]      cfg_eff_ps,
  output logic            rd_req,
  output logic [PA_W-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [63:0]     rd_data,
  input  logic            rd_err,
  output logic            busy,
  output logic            done,
  output logic [2:0]      fault,
  output logic            fault_s2,
  output logic [PA_W-1:0] pa,
  output logic [PA_W-1:0] pa_mask,
  output logic [1:0]      leaf_level,
  output logic [1:0]      perm
);

  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_TRANS = 3'd1;
  localparam logic [2:0] F_ACC   = 3'd2;
  localparam logic [2:0] F_PERM  = 3'd3;
  localparam logic [2:0] F_SIZE  = 3'd4;
  localparam logic [2:0] F_EXT   = 3'd5;

  typedef enum logic {IDLE, WALK} state_t;

  state_t          st;
  logic [IA_W-1:0] ipa_q;
  logic            wr_q;
  logic [1:0]      lvl_q;
  logic            root_q;
  logic [PA_W-1:0] base_q;

  function automatic logic [6:0] lvl_shift(input logic g64, input logic [1:0] l);
    logic [6:0] d;
    d = {5'd0, 2'd3 - l};
    return g64 ? 7'd16 + 7'd13 * d : 7'd12 + 7'd9 * d;
  endfunction

  logic [6:0]      sh, idx_bits, in_bits;
  logic [IA_W-1:0] off;
  logic [PA_W-1:0] blk_mask, gran_mask, desc_oa, nxt_tbl;
  logic            last, blk_ok, is_tbl, is_leaf, perm_ok, oa_big;
  logic            ia_big, rng_big, sl0_bad;
  logic [1:0]      start_lvl, ap;

  assign sh        = lvl_shift(cfg_gran64k, lvl_q);
  assign idx_bits  = (cfg_gran64k ? 7'd13 : 7'd9) + (root_q ? 7'(CAT_W) : 7'd0);
  assign off       = (ipa_q >> sh) & ~({IA_W{1'b1}} << idx_bits);
  assign rd_addr   = base_q + {off[PA_W-4:0], 3'b000};
  assign rd_req    = (st == WALK);
  assign busy      = (st == WALK);

  assign blk_mask  = ~({PA_W{1'b1}} << sh);
  assign gran_mask = cfg_gran64k ? PA_W'(16'hFFFF) : PA_W'(12'hFFF);
  assign desc_oa   = rd_data[PA_W-1:0] & ~blk_mask;
  assign nxt_tbl   = rd_data[PA_W-1:0] & ~gran_mask;
  assign last      = (lvl_q == 2'd3);
  assign blk_ok    = cfg_gran64k ? (lvl_q == 2'd2) : (lvl_q != 2'd0);
  assign is_tbl    = rd_data[0] & rd_data[1] & ~last;
  assign is_leaf   = rd_data[0] & (last ? rd_data[1] : (~rd_data[1] & blk_ok));
  assign ap        = rd_data[7:6];
  assign perm_ok   = wr_q ? ap[1] : ap[0];
  assign oa_big    = (({{(IA_W-PA_W){1'b0}}, desc_oa} >> cfg_eff_ps) != '0);

  assign in_bits   = 7'(IA_W) - {1'b0, cfg_s2tsz};
  assign ia_big    = cfg_s1_bypass && ((ipa >> cfg_oas) != '0);
  assign rng_big   = ((ipa >> in_bits) != '0);
  assign sl0_bad   = (cfg_sl0 == 2'd3);
  assign start_lvl = cfg_gran64k ? 2'd3 - cfg_sl0 : 2'd2 - cfg_sl0;

  logic unused_bits;
  assign unused_bits = ^{rd_data[63:PA_W], rd_data[9:8], rd_data[5:2], off[IA_W-1:PA_W-3]};

  logic       fin;
  logic [2:0] fcode;
  logic       fs2;

  always_comb begin
    fin   = 1'b0;
    fcode = F_NONE;
    fs2   = 1'b1;
    if (st == IDLE && start) begin
      if (ia_big) begin
        fin = 1'b1; fcode = F_SIZE; fs2 = 1'b0;
      end else if (rng_big || sl0_bad) begin
        fin = 1'b1; fcode = F_TRANS;
      end
    end else if (st == WALK && rd_ack) begin
      if (rd_err) begin
        fin = 1'b1; fcode = F_EXT;
      end else if (!is_tbl) begin
        fin = 1'b1;
        if (!is_leaf)                  fcode = F_TRANS;
        else if (!rd_data[10] && !cfg_affd) fcode = F_ACC;
        else if (!perm_ok)             fcode = F_PERM;
        else if (oa_big)               fcode = F_SIZE;
        else                           fs2 = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ipa_q <= '0; wr_q <= 1'b0; lvl_q <= '0; root_q <= 1'b0; base_q <= '0;
      done <= 1'b0; fault <= F_NONE; fault_s2 <= 1'b0;
      pa <= '0; pa_mask <= '0; leaf_level <= '0; perm <= '0;
    end else begin
      done <= 1'b0;
      if (st == IDLE && start) begin
        ipa_q  <= ipa;
        wr_q   <= is_write;
        lvl_q  <= start_lvl;
        root_q <= 1'b1;
        base_q <= cfg_vttb;
        if (!fin) st <= WALK;
      end else if (st == WALK && rd_ack && !rd_err && is_tbl) begin
        base_q <= nxt_tbl;
        lvl_q  <= lvl_q + 2'd1;
        root_q <= 1'b0;
      end
      if (fin) begin
        st         <= IDLE;
        done       <= 1'b1;
        fault      <= fcode;
        fault_s2   <= fs2;
        pa         <= (fcode == F_NONE) ? desc_oa  : '0;
        pa_mask    <= (fcode == F_NONE) ? blk_mask : '0;
        leaf_level <= (fcode == F_NONE) ? lvl_q    : 2'd0;
        perm       <= (fcode == F_NONE) ? ap       : 2'd0;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  p_stage1_only_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != F_NONE && !fault_s2) |-> fault == F_SIZE);

  p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 2'd1));

  p_grant_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_NONE) |-> perm != 2'd0);

  p_fault_noperm_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != F_NONE) |-> (perm == 2'd0 && pa_mask == '0));

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_done_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/s2_ipa_walker_tb.sv
module s2_ipa_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ipa = '0;
  logic        is_write = 1'b0;
  logic        cfg_s1_bypass, cfg_gran64k, cfg_affd;
  logic [5:0]  cfg_oas, cfg_s2tsz, cfg_eff_ps;
  logic [1:0]  cfg_sl0;
  logic [47:0] cfg_vttb;
  logic        rd_req, rd_ack, rd_err, busy, done, fault_s2;
  logic [47:0] rd_addr, pa, pa_mask;
  logic [63:0] rd_data;
  logic [2:0]  fault;
  logic [1:0]  leaf_level, perm;

  localparam logic [47:0] VT = 48'h1000_0000;

  int nchk = 0, nerr = 0, nreads = 0, lat = 0, wcnt = 0, ndone = 0;
  logic [63:0] mem [logic [47:0]];
  logic [47:0] first_addr;

  always #2 clk = ~clk;

  s2_ipa_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ipa(ipa), .is_write(is_write),
    .cfg_s1_bypass(cfg_s1_bypass), .cfg_oas(cfg_oas), .cfg_s2tsz(cfg_s2tsz),
    .cfg_gran64k(cfg_gran64k), .cfg_sl0(cfg_sl0), .cfg_vttb(cfg_vttb),
    .cfg_affd(cfg_affd), .cfg_eff_ps(cfg_eff_ps),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .busy(busy), .done(done), .fault(fault), .fault_s2(fault_s2),
    .pa(pa), .pa_mask(pa_mask), .leaf_level(leaf_level), .perm(perm)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0; rd_err <= 1'b0; rd_data <= '0; wcnt <= 0;
    end else if (rd_ack) begin
      rd_ack <= 1'b0; rd_err <= 1'b0;
    end else if (rd_req) begin
      if (wcnt < lat) wcnt <= wcnt + 1;
      else begin
        wcnt    <= 0;
        rd_ack  <= 1'b1;
        rd_err  <= !mem.exists(rd_addr);
        rd_data <= mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
        if (nreads == 0) first_addr <= rd_addr;
        nreads  <= nreads + 1;
      end
    end
    if (done) ndone <= ndone + 1;
  end

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] d_tbl(input logic [47:0] a);
    return {16'h0, a} | 64'h3;
  endfunction
  function automatic logic [63:0] d_leaf(input logic [47:0] a, input logic [1:0] ap,
                                         input logic af, input logic pg);
    return {16'h0, a} | (64'(af) << 10) | (64'(ap) << 6) | {62'h0, pg, 1'b1};
  endfunction
  function automatic logic [47:0] ea(input logic [47:0] b, input logic [63:0] a,
                                     input int sh, input int bits);
    return b + 48'(((a >> sh) & ((64'd1 << bits) - 64'd1)) << 3);
  endfunction

  task automatic setup(input logic g64, input logic [5:0] tsz, input logic [1:0] sl0);
    mem.delete();
    cfg_s1_bypass = 1'b0; cfg_oas = 6'd48; cfg_gran64k = g64; cfg_s2tsz = tsz;
    cfg_sl0 = sl0; cfg_vttb = VT; cfg_affd = 1'b0; cfg_eff_ps = 6'd48; lat = 0;
  endtask

  task automatic walk(input logic [63:0] a, input logic w);
    int n;
    @(negedge clk);
    nreads = 0;
    ipa = a; is_write = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk("R14 walk completes", {63'd0, done}, 64'd1);
  endtask

  task automatic expect_ok(input string tag, input logic [47:0] epa, input logic [47:0] emask,
                           input logic [1:0] elvl, input logic [1:0] eperm);
    chk({tag, " fault"}, {61'd0, fault}, 64'd0);
    chk({tag, " pa"}, {16'd0, pa}, {16'd0, epa});
    chk({tag, " mask"}, {16'd0, pa_mask}, {16'd0, emask});
    chk({tag, " level"}, {62'd0, leaf_level}, {62'd0, elvl});
    chk({tag, " perm"}, {62'd0, perm}, {62'd0, eperm});
  endtask

  task automatic expect_flt(input string tag, input logic [2:0] ef, input logic es2, input int erd);
    chk({tag, " code"}, {61'd0, fault}, {61'd0, ef});
    chk({tag, " stage"}, {63'd0, fault_s2}, {63'd0, es2});
    chk({tag, " R13 perm"}, {62'd0, perm}, 64'd0);
    if (erd >= 0) chk({tag, " reads"}, 64'(nreads), 64'(erd));
  endtask

  task automatic t_reset;
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 rd_req", {63'd0, rd_req}, 64'd0);
  endtask

  task automatic t_page_chain;
    logic [63:0] a = 64'h12_3456_7ABC;
    setup(1'b0, 6'd25, 2'd1);
    mem[ea(VT, a, 30, 9)] = d_tbl(48'h2000_0000);
    mem[ea(48'h2000_0000, a, 21, 9)] = d_tbl(48'h2100_0000);
    mem[ea(48'h2100_0000, a, 12, 9)] = d_leaf(48'h8_7654_3000, 2'b11, 1'b1, 1'b1);
    walk(a, 1'b1);
    expect_ok("R6 R7 page chain", 48'h8_7654_3000, 48'hFFF, 2'd3, 2'b11);
    chk("R6 three reads", 64'(nreads), 64'd3);
    chk("R4 sl0=1 first read", {16'd0, first_addr}, {16'd0, ea(VT, a, 30, 9)});
  endtask

  task automatic t_block_l2;
    logic [63:0] a = 64'h05_5555_1234;
    setup(1'b0, 6'd25, 2'd1);
    mem[ea(VT, a, 30, 9)] = d_tbl(48'h3000_0000);
    mem[ea(48'h3000_0000, a, 21, 9)] = d_leaf(48'h4_0020_1000, 2'b01, 1'b1, 1'b0);
    walk(a, 1'b0);
    expect_ok("R7 block L2", 48'h4_0020_0000, 48'h1F_FFFF, 2'd2, 2'b01);
  endtask

  task automatic t_concat;
    logic [63:0] a = (64'd1 << 39) | (64'd5 << 30) | 64'h1234;
    setup(1'b0, 6'd24, 2'd1);
    mem[VT + 48'd4096 + 48'd40] = d_leaf(48'h1_4000_0000, 2'b11, 1'b1, 1'b0);
    mem[VT + 48'd40] = d_leaf(48'h2_0000_0000, 2'b11, 1'b1, 1'b0);
    walk(a, 1'b0);
    expect_ok("R5 concat idx1", 48'h1_4000_0000, 48'h3FFF_FFFF, 2'd1, 2'b11);
    walk(a & ~(64'd1 << 39), 1'b0);
    expect_ok("R5 concat idx0", 48'h2_0000_0000, 48'h3FFF_FFFF, 2'd1, 2'b11);
  endtask

  task automatic t_start_levels;
    logic [63:0] d = 64'h8123_4567_8000;
    logic [63:0] e = 64'h2ABC_DEF0;
    logic [63:0] f = 64'h2_3456_789A;
    setup(1'b0, 6'd16, 2'd2);
    mem[ea(VT, d, 39, 9)] = d_tbl(48'h3000_0000);
    mem[ea(48'h3000_0000, d, 30, 9)] = d_leaf(48'h7_C000_0000, 2'b01, 1'b1, 1'b0);
    walk(d, 1'b0);
    expect_ok("R4 sl0=2 start L0", 48'h7_C000_0000, 48'h3FFF_FFFF, 2'd1, 2'b01);
    chk("R4 sl0=2 reads", 64'(nreads), 64'd2);
    setup(1'b0, 6'd34, 2'd0);
    mem[ea(VT, e, 21, 9)] = d_leaf(48'h5_0020_0000, 2'b10, 1'b1, 1'b0);
    walk(e, 1'b1);
    expect_ok("R4 sl0=0 start L2", 48'h5_0020_0000, 48'h1F_FFFF, 2'd2, 2'b10);
    chk("R4 sl0=0 reads", 64'(nreads), 64'd1);
    setup(1'b1, 6'd22, 2'd1);
    mem[ea(VT, f, 29, 13)] = d_tbl(48'h60_8000);
    mem[ea(48'h60_0000, f, 16, 13)] = d_leaf(48'h5_0001_0000, 2'b01, 1'b1, 1'b1);
    walk(f, 1'b0);
    expect_ok("R4 R6 64KB chain", 48'h5_0001_0000, 48'hFFFF, 2'd3, 2'b01);
  endtask

  task automatic t_input_faults;
    setup(1'b0, 6'd25, 2'd1);
    cfg_s1_bypass = 1'b1; cfg_oas = 6'd32;
    walk(64'h1_0000_0000, 1'b0);
    expect_flt("R2 oas", 3'd4, 1'b0, 0);
    walk(64'd1 << 40, 1'b0);
    expect_flt("R2 priority", 3'd4, 1'b0, 0);
    cfg_s1_bypass = 1'b0;
    walk(64'd1 << 40, 1'b0);
    expect_flt("R3 range", 3'd1, 1'b1, 0);
    walk(64'd1 << 39, 1'b0);
    expect_flt("R3 range edge", 3'd1, 1'b1, 0);
    cfg_sl0 = 2'd3;
    walk(64'h1000, 1'b0);
    expect_flt("R3 sl0 reserved", 3'd1, 1'b1, 0);
  endtask

  task automatic t_leaf_checks;
    logic [63:0] e = 64'h2ABC_DEF0;
    setup(1'b0, 6'd34, 2'd0);
    mem[ea(VT, e, 21, 9)] = d_leaf(48'h5_0020_0000, 2'b00, 1'b0, 1'b0);
    walk(e, 1'b1);
    expect_flt("R9 access first", 3'd2, 1'b1, 1);
    cfg_affd = 1'b1;
    walk(e, 1'b1);
    expect_flt("R10 after affd", 3'd3, 1'b1, 1);
    cfg_affd = 1'b0;
    mem[ea(VT, e, 21, 9)] = d_leaf(48'h5_0020_0000, 2'b01, 1'b1, 1'b0);
    walk(e, 1'b1);
    expect_flt("R10 write denied", 3'd3, 1'b1, 1);
    mem[ea(VT, e, 21, 9)] = d_leaf(48'h5_0020_0000, 2'b10, 1'b1, 1'b0);
    walk(e, 1'b0);
    expect_flt("R10 read denied", 3'd3, 1'b1, 1);
    cfg_eff_ps = 6'd32;
    mem[ea(VT, e, 21, 9)] = d_leaf(48'h1_0000_0000, 2'b11, 1'b1, 1'b0);
    walk(e, 1'b0);
    expect_flt("R11 output size", 3'd4, 1'b1, 1);
    mem[ea(VT, e, 21, 9)] = d_leaf(48'hFFE0_0000, 2'b11, 1'b1, 1'b0);
    walk(e, 1'b0);
    expect_ok("R11 output at limit", 48'hFFE0_0000, 48'h1F_FFFF, 2'd2, 2'b11);
  endtask

  task automatic t_bad_desc;
    logic [63:0] e = 64'h2ABC_DEF0;
    logic [63:0] d = 64'h8123_4567_8000;
    setup(1'b0, 6'd34, 2'd0);
    mem[ea(VT, e, 21, 9)] = 64'h0;
    walk(e, 1'b0);
    expect_flt("R8 invalid", 3'd1, 1'b1, 1);
    mem[ea(VT, e, 21, 9)] = d_tbl(48'h3300_0000);
    mem[ea(48'h3300_0000, e, 12, 9)] = d_leaf(48'h9000, 2'b11, 1'b1, 1'b0);
    walk(e, 1'b0);
    expect_flt("R8 L3 reserved", 3'd1, 1'b1, 2);
    setup(1'b0, 6'd16, 2'd2);
    mem[ea(VT, d, 39, 9)] = d_leaf(48'h0, 2'b11, 1'b1, 1'b0);
    walk(d, 1'b0);
    expect_flt("R8 L0 block", 3'd1, 1'b1, 1);
    mem.delete();
    walk(d, 1'b0);
    expect_flt("R12 abort", 3'd5, 1'b1, 1);
  endtask

  task automatic t_slow_and_restart;
    logic [63:0] a = 64'h12_3456_7ABC;
    int n;
    setup(1'b0, 6'd25, 2'd1);
    lat = 3;
    mem[ea(VT, a, 30, 9)] = d_tbl(48'h2000_0000);
    mem[ea(48'h2000_0000, a, 21, 9)] = d_tbl(48'h2100_0000);
    mem[ea(48'h2100_0000, a, 12, 9)] = d_leaf(48'h8_7654_3000, 2'b11, 1'b1, 1'b1);
    @(negedge clk);
    nreads = 0; ndone = 0;
    ipa = a; is_write = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    ipa = 64'd1 << 40; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    expect_ok("R14 slow memory", 48'h8_7654_3000, 48'hFFF, 2'd3, 2'b11);
    repeat (4) @(negedge clk);
    chk("R14 one done", 64'(ndone), 64'd1);
    chk("R1 idle after walk", {63'd0, rd_req}, 64'd0);
  endtask

  initial begin
    setup(1'b0, 6'd25, 2'd1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_chain();
    t_block_l2();
    t_concat();
    t_start_levels();
    t_input_faults();
    t_leaf_checks();
    t_bad_desc();
    t_slow_and_restart();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule